// File: doc/BRIEF.md
# Bus Head Receive Deframer

This block sits behind the receiving UART at the head of a multi-drop serial bus. Every payload byte crosses the bus as two characters. Each character carries half of a 6-bit header and half of the data byte. The character's top bit tells whether it opens a frame (0) or closes it (1). The block pairs these characters and extracts the header and the byte. It then files the byte into a buffer that belongs to the drop whose ID sits in the header.

Each drop gathers bytes until a zero byte arrives. The zero byte ends the packet and raises that drop's ready flag. A host selects a drop and reads back the length and the stored bytes at addresses of its choice. It then pulses a clear, which empties the buffer for the next packet. The bytes are stored as they arrive and are not decoded from their stuffed form.

Top module: `bus_head_deframer`

## Requirements
- R1: A character received with `rx_perr` high is discarded. It neither opens nor completes a frame and does not disturb a pending first half.
- R2: A parity-clean character with bit 7 = 0 is kept as the pending first half, and a newer one replaces an older one. A parity-clean character with bit 7 = 1 completes a frame with the most recent pending first half.
- R3: A bit-7 = 1 character with no pending first half is discarded. Completing a frame consumes the pending first half.
- R4: The header is {first[6:4], second[6:4]} and the data byte is {first[3:0], second[3:0]}. The drop ID is header[3:0]; header[5:4] does not affect routing.
- R5: A frame whose drop ID is NUM_DROPS (14) or more changes no drop's state.
- R6: A non-zero byte for a drop is stored at that drop's write pointer, and the pointer then advances by one. `rd_data` returns the byte at {`rd_drop`, `rd_addr`} one clock edge after the address is applied.
- R7: A zero byte closes the drop's packet. `pkt_ready[d]` rises on the second clock edge after the completing character is sampled. `rd_len` then shows the count of non-zero bytes stored.
- R8: While a drop's ready flag is set, further frames for that drop are discarded, and its length and contents stay unchanged.
- R9: A `rd_clear` pulse for the drop on `rd_drop` zeroes its pointer, ready flag and overflow flag, so `rd_len` reads 0.
- R10: When a byte for a drop arrives on the same edge as that drop's clear, the clear acts first. The byte becomes the first byte of a new packet.
- R11: Once a drop holds DEPTH bytes, further non-zero bytes are discarded and its `ovf_flag` bit is set. The bit stays set until cleared. A zero byte still closes the packet with length DEPTH.
- R12: Drops fill independently, so frames interleaved across drops build separate packets.
- R13: After reset, no drop is ready or overflowed, and `rd_len` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_data | input | 8 | Received character |
| rx_valid | input | 1 | One-cycle strobe, `rx_data` is valid |
| rx_perr | input | 1 | Parity error on the current character |
| rd_drop | input | 4 | Drop selected for length, read and clear |
| rd_addr | input | $clog2(DEPTH) | Byte address within the selected drop |
| rd_clear | input | 1 | Empty the selected drop's buffer |
| pkt_ready | output | NUM_DROPS | Per-drop complete-packet flag |
| ovf_flag | output | NUM_DROPS | Per-drop sticky overflow flag |
| rd_len | output | $clog2(DEPTH)+1 | Packet length of the selected drop (0 if not ready) |
| rd_data | output | 8 | Registered byte read from the selected drop |

## Verification
Clean pairs are sent with header bits 5:4 set to non-zero values, which shows that routing uses only the drop field and that each nibble lands in the right place. Orderings are then tried that separate the pairing rules. These are a repeated first half, parity-errored characters of both kinds placed between the halves, and an orphan second half after a completed frame. Each of these leaves a different byte, or no byte, in the buffer. Interleaved drops, out-of-range drop IDs, and bytes sent to an already-ready drop show whether state is kept per drop. A buffer filled past DEPTH, and a clear that lands on the same edge as an incoming byte, cover the two boundary behaviours.

// File: rtl/bhd_pkg.sv
package bhd_pkg;
    localparam int CHAR_W = 8;
    localparam int HDR_W  = 6;
    localparam int DROP_W = 4;

    typedef struct packed {
        logic              valid;
        logic [HDR_W-1:0]  hdr;
        logic [CHAR_W-1:0] data;
    } frame_t;

    // header: upper half from the opening character, lower half from the closing one
    function automatic logic [HDR_W-1:0] hdr_of(input logic [CHAR_W-1:0] opener,
                                                input logic [CHAR_W-1:0] closer);
        return {opener[6:4], closer[6:4]};
    endfunction

    function automatic logic [CHAR_W-1:0] byte_of(input logic [CHAR_W-1:0] opener,
                                                 input logic [CHAR_W-1:0] closer);
        return {opener[3:0], closer[3:0]};
    endfunction

    function automatic logic [DROP_W-1:0] drop_of(input logic [HDR_W-1:0] hdr);
        return hdr[DROP_W-1:0];
    endfunction
endpackage

// File: rtl/bhd_pairer.sv
module bhd_pairer
    import bhd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_valid,
    input  logic              rx_perr,
    output frame_t            frm
);
    typedef struct packed {
        logic              have_first;
        logic [CHAR_W-1:0] first;
        frame_t            frm;
    } pair_st_t;

    pair_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.frm.valid = 1'b0;
        if (rx_valid && !rx_perr) begin
            if (!rx_data[CHAR_W-1]) begin
                st_d.have_first = 1'b1;
                st_d.first      = rx_data;
            end else if (st_q.have_first) begin
                st_d.frm.valid  = 1'b1;
                st_d.frm.hdr    = hdr_of(st_q.first, rx_data);
                st_d.frm.data   = byte_of(st_q.first, rx_data);
                st_d.have_first = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frm = st_q.frm;

    // R1: a parity-errored character leaves the pairing state alone and yields no frame
    p_perr_discard_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_perr) |=> (!frm.valid && $stable(st_q.have_first) && $stable(st_q.first)));

    // R3: a closing character without a pending opener yields no frame
    p_orphan_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_perr && rx_data[CHAR_W-1] && !st_q.have_first) |=> !frm.valid);

    // R3: a completed frame consumes the opener
    p_opener_consumed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frm.valid) |-> !st_q.have_first);
endmodule

// File: rtl/bhd_drop_ctrl.sv
module bhd_drop_ctrl
    import bhd_pkg::*;
#(
    parameter int NUM_DROPS = 14,
    parameter int DEPTH     = 128,
    localparam int AW       = $clog2(DEPTH),
    localparam int LEN_W    = AW + 1,
    localparam int MW       = DROP_W + AW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  frame_t               frm,
    input  logic [DROP_W-1:0]    rd_drop,
    input  logic                 rd_clear,
    output logic                 wr_en,
    output logic [MW-1:0]        wr_addr,
    output logic [CHAR_W-1:0]    wr_data,
    output logic [NUM_DROPS-1:0] ready,
    output logic [NUM_DROPS-1:0] ovf,
    output logic [LEN_W-1:0]     rd_len
);
    typedef struct packed {
        logic [NUM_DROPS-1:0][LEN_W-1:0] ptr;
        logic [NUM_DROPS-1:0]            ready;
        logic [NUM_DROPS-1:0]            ovf;
    } drop_st_t;

    drop_st_t          st_d, st_q;
    logic [DROP_W-1:0] fd;
    logic              clr_hit;
    logic              frm_ok;
    logic              rd_ok;

    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = frm.data;
        fd      = drop_of(frm.hdr);
        clr_hit = rd_clear && (int'(rd_drop) < NUM_DROPS);
        frm_ok  = frm.valid && (int'(fd) < NUM_DROPS);

        // the clear is applied first so a coinciding byte opens a fresh packet
        if (clr_hit) begin
            st_d.ptr[rd_drop]   = '0;
            st_d.ready[rd_drop] = 1'b0;
            st_d.ovf[rd_drop]   = 1'b0;
        end

        if (frm_ok && !st_d.ready[fd]) begin
            if (frm.data == '0) begin
                st_d.ready[fd] = 1'b1;
            end else if (st_d.ptr[fd] == LEN_W'(DEPTH)) begin
                st_d.ovf[fd] = 1'b1;
            end else begin
                wr_en        = 1'b1;
                wr_addr      = {fd, st_d.ptr[fd][AW-1:0]};
                st_d.ptr[fd] = st_d.ptr[fd] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_ok  = int'(rd_drop) < NUM_DROPS;
    assign ready  = st_q.ready;
    assign ovf    = st_q.ovf;
    assign rd_len = (rd_ok && st_q.ready[rd_drop]) ? st_q.ptr[rd_drop] : '0;

    // R6: an accepted non-zero byte advances its drop's pointer by one
    p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm.valid && int'(drop_of(frm.hdr)) < NUM_DROPS && frm.data != '0 && !rd_clear
         && !st_q.ready[drop_of(frm.hdr)] && st_q.ptr[drop_of(frm.hdr)] < LEN_W'(DEPTH))
        |=> st_q.ptr[$past(drop_of(frm.hdr))] == $past(st_q.ptr[drop_of(frm.hdr)]) + 1'b1);

    // R5: an out-of-range drop leaves every drop untouched
    p_bad_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frm.valid && int'(drop_of(frm.hdr)) >= NUM_DROPS && !rd_clear)
        |=> ($stable(st_q.ptr) && $stable(st_q.ready) && $stable(st_q.ovf)));

    // R8: a ready drop ignores further frames
    p_ready_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frm.valid && int'(drop_of(frm.hdr)) < NUM_DROPS && st_q.ready[drop_of(frm.hdr)] && !rd_clear)
        |=> $stable(st_q.ptr));

    // R9: a clear with no incoming frame empties the drop
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && rd_ok && !frm.valid)
        |=> (st_q.ptr[$past(rd_drop)] == '0 && !st_q.ready[$past(rd_drop)] && !st_q.ovf[$past(rd_drop)]));

    // R11: a non-zero byte to a full drop raises overflow without moving the pointer
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (frm.valid && int'(drop_of(frm.hdr)) < NUM_DROPS && frm.data != '0 && !rd_clear
         && !st_q.ready[drop_of(frm.hdr)] && st_q.ptr[drop_of(frm.hdr)] == LEN_W'(DEPTH))
        |=> (st_q.ovf[$past(drop_of(frm.hdr))]
             && st_q.ptr[$past(drop_of(frm.hdr))] == LEN_W'(DEPTH)));

    for (genvar g = 0; g < NUM_DROPS; g++) begin : g_drop_chk
        // R11: overflow is sticky until that drop is cleared
        p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.ovf[g] && !(rd_clear && int'(rd_drop) == g)) |=> st_q.ovf[g]);
        // R11: a pointer never passes the buffer depth
        p_ptr_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.ptr[g] <= LEN_W'(DEPTH));
    end
endmodule

// File: rtl/bhd_buf_mem.sv
module bhd_buf_mem
    import bhd_pkg::*;
#(
    parameter int NUM_DROPS = 14,
    parameter int DEPTH     = 128,
    localparam int AW       = $clog2(DEPTH),
    localparam int MW       = DROP_W + AW,
    localparam int ENTRIES  = NUM_DROPS * DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MW-1:0]     wr_addr,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic [DROP_W-1:0] rd_drop,
    input  logic [AW-1:0]     rd_addr,
    output logic [CHAR_W-1:0] rd_data
);
    logic [CHAR_W-1:0] mem [ENTRIES];
    logic [MW-1:0]     raddr;
    logic [CHAR_W-1:0] rd_d, rd_q;

    assign raddr = {rd_drop, rd_addr};

    always_ff @(posedge clk) begin
        if (wr_en) mem[int'(wr_addr)] <= wr_data;
    end

    always_comb begin
        rd_d = '0;
        if (int'(rd_drop) < NUM_DROPS) rd_d = mem[int'(raddr)];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    // R6: writes stay inside the storage of existing drops
    p_wr_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> int'(wr_addr) < ENTRIES);
endmodule

// File: rtl/bus_head_deframer.sv
module bus_head_deframer
    import bhd_pkg::*;
#(
    parameter int NUM_DROPS = 14,
    parameter int DEPTH     = 128,
    localparam int AW       = $clog2(DEPTH),
    localparam int LEN_W    = AW + 1,
    localparam int MW       = DROP_W + AW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           rx_data,
    input  logic                 rx_valid,
    input  logic                 rx_perr,
    input  logic [3:0]           rd_drop,
    input  logic [AW-1:0]        rd_addr,
    input  logic                 rd_clear,
    output logic [NUM_DROPS-1:0] pkt_ready,
    output logic [NUM_DROPS-1:0] ovf_flag,
    output logic [LEN_W-1:0]     rd_len,
    output logic [7:0]           rd_data
);
    frame_t            frm;
    logic              wr_en;
    logic [MW-1:0]     wr_addr;
    logic [CHAR_W-1:0] wr_data;

    bhd_pairer u_pairer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_perr  (rx_perr),
        .frm      (frm)
    );

    bhd_drop_ctrl #(.NUM_DROPS(NUM_DROPS), .DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm      (frm),
        .rd_drop  (rd_drop),
        .rd_clear (rd_clear),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ready    (pkt_ready),
        .ovf      (ovf_flag),
        .rd_len   (rd_len)
    );

    bhd_buf_mem #(.NUM_DROPS(NUM_DROPS), .DEPTH(DEPTH)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_drop  (rd_drop),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    // R7: a drop's ready flag can only rise one edge after a frame left the pairer
    p_ready_after_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_ready == '0 && !frm.valid) |=> pkt_ready == '0);
endmodule

// File: tb/tb_bus_head_deframer.sv
module tb_bus_head_deframer;
    localparam int ND  = 14;
    localparam int DEP = 128;
    localparam int AW  = $clog2(DEP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          rx_valid = 1'b0;
    logic          rx_perr = 1'b0;
    logic [3:0]    rd_drop = '0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_clear = 1'b0;
    logic [ND-1:0] pkt_ready;
    logic [ND-1:0] ovf_flag;
    logic [AW:0]   rd_len;
    logic [7:0]    rd_data;

    bus_head_deframer #(.NUM_DROPS(ND), .DEPTH(DEP)) dut (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_perr(rx_perr), .rd_drop(rd_drop), .rd_addr(rd_addr), .rd_clear(rd_clear),
        .pkt_ready(pkt_ready), .ovf_flag(ovf_flag), .rd_len(rd_len), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    // reference model of every drop
    logic [7:0] m_mem [ND][DEP];
    int         m_ptr [ND];
    bit         m_rdy [ND];
    bit         m_ovf [ND];

    // scoreboard of expected read bytes
    logic [7:0] exp_q [$];
    string      req_q [$];
    logic       probe = 1'b0;
    logic       probe_d1 = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) probe_d1 <= probe;

    always @(negedge clk) begin
        if (probe_d1) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected read", int'(rd_data), 0);
            end else begin
                logic [7:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk(rd_data == e, r, int'(rd_data), int'(e));
            end
        end
    end

    function automatic logic [7:0] opener(input logic [1:0] u, input int d, input logic [7:0] b);
        logic [5:0] h;
        h = {u, 4'(d)};
        return {1'b0, h[5:3], b[7:4]};
    endfunction

    function automatic logic [7:0] closer(input logic [1:0] u, input int d, input logic [7:0] b);
        logic [5:0] h;
        h = {u, 4'(d)};
        return {1'b1, h[2:0], b[3:0]};
    endfunction

    task automatic model_apply(input int d, input logic [7:0] b);
        if (d < ND && !m_rdy[d]) begin
            if (b == 8'h00)        m_rdy[d] = 1'b1;
            else if (m_ptr[d] == DEP) m_ovf[d] = 1'b1;
            else begin
                m_mem[d][m_ptr[d]] = b;
                m_ptr[d]++;
            end
        end
    endtask

    task automatic model_clear(input int d);
        m_ptr[d] = 0;
        m_rdy[d] = 1'b0;
        m_ovf[d] = 1'b0;
    endtask

    task automatic send_char(input logic [7:0] c, input logic perr);
        @(negedge clk);
        rx_data  = c;
        rx_valid = 1'b1;
        rx_perr  = perr;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_perr  = 1'b0;
    endtask

    task automatic send_frame(input logic [1:0] u, input int d, input logic [7:0] b);
        send_char(opener(u, d, b), 1'b0);
        send_char(closer(u, d, b), 1'b0);
        model_apply(d, b);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic check_flags(input string req);
        logic [ND-1:0] er, eo;
        for (int i = 0; i < ND; i++) begin
            er[i] = m_rdy[i];
            eo[i] = m_ovf[i];
        end
        #1;
        chk(pkt_ready == er, req, int'(pkt_ready), int'(er));
        chk(ovf_flag == eo, req, int'(ovf_flag), int'(eo));
    endtask

    task automatic read_check(input int d, input string req);
        int len;
        len = m_rdy[d] ? m_ptr[d] : 0;
        @(negedge clk);
        rd_drop = 4'(d);
        #1;
        chk(int'(rd_len) == len, req, int'(rd_len), len);
        for (int i = 0; i < len; i++) begin
            rd_addr = AW'(i);
            probe   = 1'b1;
            exp_q.push_back(m_mem[d][i]);
            req_q.push_back(req);
            @(negedge clk);
            #1;
        end
        probe = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    task automatic clear_drop(input int d);
        @(negedge clk);
        rd_drop  = 4'(d);
        rd_clear = 1'b1;
        @(negedge clk);
        rd_clear = 1'b0;
        model_clear(d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            total++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < ND; i++) model_clear(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R13: reset state
        check_flags("R13 reset flags");
        chk(rd_len == '0, "R13 reset length", int'(rd_len), 0);

        // R4, R6: fields with non-zero upper header bits on drop 3
        send_frame(2'b11, 3, 8'h12);
        send_frame(2'b10, 3, 8'hAB);
        send_frame(2'b01, 3, 8'hF0);
        // R7: zero byte closes; ready rises on the second edge after the closer
        send_char(opener(2'b11, 3, 8'h00), 1'b0);
        @(negedge clk);
        rx_data  = closer(2'b11, 3, 8'h00);
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        #1;
        chk(pkt_ready[3] == 1'b0, "R7 ready not after one edge", int'(pkt_ready[3]), 0);
        @(negedge clk);
        #1;
        chk(pkt_ready[3] == 1'b1, "R7 ready after two edges", int'(pkt_ready[3]), 1);
        model_apply(3, 8'h00);

        // R8: more bytes to a ready drop are ignored
        send_frame(2'b00, 3, 8'h77);
        send_frame(2'b00, 3, 8'h00);
        settle();
        check_flags("R8 flags");
        read_check(3, "R4 R6 R7 R8 drop3 packet");

        // R9: clear empties the drop
        clear_drop(3);
        check_flags("R9 cleared flags");
        read_check(3, "R9 cleared length");

        // R2: a newer opener replaces the older one
        send_char(opener(2'b00, 1, 8'h45), 1'b0);
        send_char(opener(2'b00, 9, 8'h75), 1'b0);
        send_char(closer(2'b00, 9, 8'h75), 1'b0);
        model_apply(9, 8'h75);
        send_frame(2'b00, 9, 8'h00);
        settle();
        check_flags("R2 replaced opener flags");
        read_check(9, "R2 replaced opener");
        read_check(1, "R2 stale opener unused");

        // R1: parity-errored characters of both kinds between the halves
        send_char(opener(2'b00, 2, 8'h6A), 1'b0);
        send_char(opener(2'b00, 10, 8'h8C), 1'b1);
        send_char(closer(2'b00, 10, 8'h8C), 1'b1);
        send_char(closer(2'b00, 2, 8'h6A), 1'b0);
        model_apply(2, 8'h6A);
        // R3: orphan closer after a completed frame is dropped
        send_char(closer(2'b00, 2, 8'h33), 1'b0);
        send_frame(2'b00, 2, 8'h00);
        settle();
        check_flags("R1 R3 flags");
        read_check(2, "R1 R3 drop2 packet");

        // R5: out-of-range drops change nothing
        send_frame(2'b00, 14, 8'h5A);
        send_frame(2'b00, 15, 8'h00);
        send_frame(2'b00, 14, 8'h00);
        settle();
        check_flags("R5 bad drop ids");

        // R12: interleaved drops 0 and 13
        send_frame(2'b01, 0, 8'hC1);
        send_frame(2'b10, 13, 8'hD1);
        send_frame(2'b01, 0, 8'hC2);
        send_frame(2'b10, 13, 8'hD2);
        send_frame(2'b10, 13, 8'hD3);
        send_frame(2'b01, 0, 8'h00);
        settle();
        check_flags("R12 partial flags");
        send_frame(2'b10, 13, 8'h00);
        settle();
        read_check(0, "R12 drop0 packet");
        read_check(13, "R12 drop13 packet");

        // R11: fill drop 5 past its depth
        for (int i = 0; i < DEP + 2; i++) send_frame(2'b00, 5, 8'((i % 250) + 1));
        settle();
        check_flags("R11 overflow set");
        send_frame(2'b00, 5, 8'h00);
        settle();
        check_flags("R11 closed full");
        read_check(5, "R11 full packet");
        clear_drop(5);
        check_flags("R11 R9 overflow cleared");

        // R10: clear and incoming byte on the same edge for drop 7
        send_frame(2'b00, 7, 8'h11);
        send_frame(2'b00, 7, 8'h00);
        settle();
        send_char(opener(2'b00, 7, 8'h55), 1'b0);
        @(negedge clk);
        rx_data  = closer(2'b00, 7, 8'h55);
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        rd_drop  = 4'd7;
        rd_clear = 1'b1;
        @(negedge clk);
        rd_clear = 1'b0;
        model_clear(7);
        model_apply(7, 8'h55);
        settle();
        check_flags("R10 not ready yet");
        send_frame(2'b00, 7, 8'h00);
        settle();
        read_check(7, "R10 byte opens new packet");

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule